// File: doc/BRIEF.md
# PCI Configuration Access Engine

The engine takes one configuration request from a processor-side port and turns it into a single-word PCI configuration cycle on a simple target interface. The request carries a bus number, a device (slot) number, a function number, a register offset and an access size of 1, 2 or 4 bytes. From these the engine forms either a Type 0 or a Type 1 configuration address and a command word. The command word holds active-low byte enables and the read or write command code. On writes it moves the data onto the correct byte lanes. On reads it shifts and masks the returned word.

A failed access is flagged as device-not-found. An access fails when the target answers with an abort, or when it stays silent for a configurable number of cycles. A sticky abort status bit records the failure until software clears it with a one-cycle clear pulse. An optional errata mode covers targets that return a stale read word: it repeats each configuration read eight times and keeps only the final word. While one access is in flight the engine ignores new requests, so address, command and data always reach the target as one unit.

Top module: `cfg_access_engine`

## Requirements
- R1: With bus number 0 the target address is a Type 0 address. It is the OR of a single select bit at position 32 minus the device number (device 0 sets no bit), the function number in bits [10:8], and the offset with bits [1:0] forced to 0.
- R2: With a nonzero bus number the target address is a Type 1 address. It holds the bus in bits [23:16], the device in [15:11], the function in [10:8], offset bits [7:2] in [7:2], bit 1 at 0 and bit 0 at 1.
- R3: `tgt_cmd[3:0]` is 4'hA for a read and 4'hB for a write. `tgt_cmd[7:4]` holds active-low byte enables, with lane n = offset mod 4. A 1-byte access drives only lane n low. A 2-byte access drives lanes n and n+1 low, with lanes above 3 dropped. A 4-byte access drives all four lanes low (value 0).
- R4: A size other than 1, 2 or 4 raises `bad_reg` with the done pulse, returns 32'hFFFFFFFF on `rd_data`, and issues no target cycle.
- R5: Write data appears on `tgt_wdata` shifted left by 8·n bits.
- R6: On a successful read, `rd_data` is the target word shifted right by 8·n bits and masked to 8, 16 or 32 bits according to the size.
- R7: A target abort sets `abort_sts`. The access then completes with `not_found`, and a read returns 32'hFFFFFFFF.
- R8: `abort_sts` stays set until an `abort_clr` pulse arrives in a cycle with no new abort. A new abort takes priority over the clear.
- R9: In errata mode a read issues exactly 8 back-to-back target cycles and returns the word of the last one. A write issues one cycle.
- R10: `busy` is high from the cycle after acceptance until done. A request presented while busy is dropped, and the target address stays stable while busy.
- R11: If the target neither acknowledges nor aborts within TMO cycles (default 16) of valid, the cycle ends after exactly TMO valid cycles and is handled as an abort.
- R12: `done` is a single-cycle pulse at the end of each access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_write | input | 1 | 1 = configuration write |
| req_bus | input | 8 | Bus number |
| req_dev | input | 5 | Device (slot) number |
| req_fn | input | 3 | Function number |
| req_off | input | 8 | Register byte offset |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write value, right-aligned |
| errata_mode | input | 1 | Repeat reads eight times |
| abort_clr | input | 1 | Write-one-to-clear pulse for abort_sts |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| bad_reg | output | 1 | Illegal size, valid with done |
| not_found | output | 1 | Access failed, valid with done |
| rd_data | output | 32 | Read result, valid with done |
| abort_sts | output | 1 | Sticky master-abort status |
| tgt_valid | output | 1 | Target cycle request |
| tgt_addr | output | 32 | Configuration address |
| tgt_cmd | output | 8 | Byte enables [7:4], command [3:0] |
| tgt_wdata | output | 32 | Lane-aligned write data |
| tgt_ack | input | 1 | Target completes the cycle |
| tgt_abort | input | 1 | Target aborts the cycle |
| tgt_rdata | input | 32 | Target read word, valid with ack |

## Verification
The hardest case to reach is the errata read, where only the eighth of eight back-to-back target words may reach `rd_data`. The bench target returns a different word on every handshake: a base plus a running handshake count. A result taken from any earlier iteration therefore gives a wrong value, and the number of valid cycles is counted as well. The timeout and the request-while-busy cases need a silent target. The bench holds the target mute, pulses a second request mid-access, and then counts valid cycles and idle state.

// File: rtl/cfg_access_engine.sv
module cfg_access_engine #(
  parameter int TMO  = 16,
  parameter int RUNS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [7:0]  req_bus,
  input  logic [4:0]  req_dev,
  input  logic [2:0]  req_fn,
  input  logic [7:0]  req_off,
  input  logic [2:0]  req_size,
  input  logic [31:0] req_wdata,
  input  logic        errata_mode,
  input  logic        abort_clr,
  output logic        busy,
  output logic        done,
  output logic        bad_reg,
  output logic        not_found,
  output logic [31:0] rd_data,
  output logic        abort_sts,
  output logic        tgt_valid,
  output logic [31:0] tgt_addr,
  output logic [7:0]  tgt_cmd,
  output logic [31:0] tgt_wdata,
  input  logic        tgt_ack,
  input  logic        tgt_abort,
  input  logic [31:0] tgt_rdata
);
  localparam int TW = $clog2(TMO + 1);
  localparam int IW = $clog2(RUNS + 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} st_t;
  st_t st;

  logic [1:0]  lane, lane_q;
  logic [2:0]  size_q;
  logic        size_ok, is_wr, errata_q, ab_q, bad_q;
  logic [3:0]  be;
  logic [32:0] sel0;
  logic [31:0] addr_c, raw_q, mask;
  logic [TW-1:0] tmr;
  logic [IW-1:0] iter;
  logic        tmo_hit, resp, accept;

  assign lane    = req_off[1:0];
  assign size_ok = (req_size == 3'd1) || (req_size == 3'd2) || (req_size == 3'd4);
  assign accept  = (st == S_IDLE) && req_valid;

  always_comb begin
    case (req_size)
      3'd1:    be = ~(4'b0001 << lane);
      3'd2:    be = ~(4'b0011 << lane);
      default: be = 4'b0000;
    endcase
  end

  assign sel0   = 33'd1 << (6'd32 - {1'b0, req_dev});
  assign addr_c = (req_bus == 8'd0)
                ? (sel0[31:0] | {21'd0, req_fn, req_off[7:2], 2'b00})
                : {8'd0, req_bus, req_dev, req_fn, req_off[7:2], 2'b01};

  assign tmo_hit = !tgt_ack && !tgt_abort && (tmr == TW'(TMO - 1));
  assign resp    = tgt_ack || tgt_abort || tmo_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      tgt_addr <= '0; tgt_cmd <= '0; tgt_wdata <= '0;
      lane_q <= '0; size_q <= '0; is_wr <= 1'b0; errata_q <= 1'b0;
      ab_q <= 1'b0; bad_q <= 1'b0; raw_q <= '0; tmr <= '0; iter <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          lane_q <= lane; size_q <= req_size; is_wr <= req_write;
          errata_q <= errata_mode; ab_q <= 1'b0; tmr <= '0; iter <= '0;
          bad_q <= !size_ok;
          tgt_addr  <= addr_c;
          tgt_cmd   <= {be, req_write ? 4'hB : 4'hA};
          tgt_wdata <= req_wdata << {lane, 3'b000};
          st <= size_ok ? S_RUN : S_FIN;
        end
        S_RUN: if (resp) begin
          if (tgt_ack) raw_q <= tgt_rdata;
          ab_q <= ab_q || tgt_abort || tmo_hit;
          tmr <= '0;
          if (!is_wr && errata_q && iter != IW'(RUNS - 1)) iter <= iter + 1'b1;
          else st <= S_FIN;
        end else begin
          tmr <= tmr + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) abort_sts <= 1'b0;
    else if (st == S_RUN && (tgt_abort || tmo_hit)) abort_sts <= 1'b1;
    else if (abort_clr) abort_sts <= 1'b0;
  end

  always_comb begin
    case (size_q)
      3'd1:    mask = 32'h0000_00FF;
      3'd2:    mask = 32'h0000_FFFF;
      default: mask = 32'hFFFF_FFFF;
    endcase
  end

  assign busy      = (st != S_IDLE);
  assign tgt_valid = (st == S_RUN);
  assign done      = (st == S_FIN);
  assign bad_reg   = done && bad_q;
  assign not_found = done && ab_q;
  assign rd_data   = !done ? 32'd0
                   : (ab_q || bad_q) ? 32'hFFFF_FFFF
                   : ((raw_q >> {lane_q, 3'b000}) & mask);
endmodule

module cfg_access_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        not_found,
  input logic        abort_sts,
  input logic        abort_clr,
  input logic        tgt_valid,
  input logic        tgt_abort,
  input logic [31:0] tgt_addr
);
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_valid_in_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_valid |-> busy);
  p_addr_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(tgt_addr));
  p_abort_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_valid && tgt_abort) |=> abort_sts);
  p_notfound_sts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    not_found |-> abort_sts);
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_sts && !abort_clr) |=> abort_sts);
endmodule

bind cfg_access_engine cfg_access_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .not_found(not_found),
  .abort_sts(abort_sts), .abort_clr(abort_clr), .tgt_valid(tgt_valid),
  .tgt_abort(tgt_abort), .tgt_addr(tgt_addr)
);

// File: tb/sim_cfg_access_engine.sv
`timescale 1ns/1ps
module sim_cfg_access_engine;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, errata_mode = 0, abort_clr = 0;
  logic [7:0] req_bus = 0, req_off = 0;
  logic [4:0] req_dev = 0;
  logic [2:0] req_fn = 0, req_size = 0;
  logic [31:0] req_wdata = 0;
  logic busy, done, bad_reg, not_found, abort_sts, tgt_valid;
  logic [31:0] rd_data, tgt_addr, tgt_wdata;
  logic [7:0] tgt_cmd;
  logic tgt_ack = 0, tgt_abort = 0;
  logic [31:0] tgt_rdata = 0;

  int checks = 0, fails = 0, cyc = 0;
  int hs = 0, vcnt = 0;
  int tmode = 0;
  logic [31:0] rbase = 0;

  cfg_access_engine u0 (.*);

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (tgt_valid) vcnt <= vcnt + 1;
    if (tgt_valid && tgt_ack) hs <= hs + 1;
    if (cyc > 20000) begin
      fails = fails + 1;
      $display("FAIL watchdog: act=%0d exp<=20000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  always @(negedge clk) begin
    tgt_ack   <= (tmode == 1) && tgt_valid;
    tgt_abort <= (tmode == 2) && tgt_valid;
    tgt_rdata <= rbase + hs;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  logic [31:0] c_addr, c_wdata, r_data;
  logic [7:0]  c_cmd;
  logic        r_bad, r_nf;
  int v0, h0;

  task automatic access(input bit wr, input [7:0] bus, input [4:0] dev, input [2:0] fn,
                        input [7:0] off, input [2:0] sz, input [31:0] wd, input bit errata,
                        input bit poke_busy);
    @(negedge clk);
    v0 = vcnt; h0 = hs;
    req_write = wr; req_bus = bus; req_dev = dev; req_fn = fn; req_off = off;
    req_size = sz; req_wdata = wd; errata_mode = errata; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    c_addr = tgt_addr; c_cmd = tgt_cmd; c_wdata = tgt_wdata;
    if (poke_busy) begin
      @(negedge clk);
      req_bus = 8'h77; req_valid = 1;
      @(negedge clk);
      req_valid = 0;
    end
    for (int i = 0; i < 400 && !done; i++) @(negedge clk);
    r_data = rd_data; r_bad = bad_reg; r_nf = not_found;
    chk(done === 1'b1, "R12 done seen", {31'd0, done}, 32'd1);
    @(negedge clk);
    chk(done === 1'b0, "R12 done one cycle", {31'd0, done}, 32'd0);
  endtask

  task automatic t_reset;
    chk(!busy && !done && !tgt_valid && !abort_sts, "R10 reset idle",
        {28'd0, busy, done, tgt_valid, abort_sts}, 32'd0);
  endtask

  task automatic t_type0_read;
    tmode = 1; rbase = 32'hAABBCCDD - hs;
    access(0, 8'd0, 5'd1, 3'd2, 8'h0E, 3'd2, 0, 0, 0);
    chk(c_addr == 32'h8000020C, "R1 type0 addr", c_addr, 32'h8000020C);
    chk(c_cmd == 8'h3A, "R3 be size2 lane2", {24'd0, c_cmd}, 32'h3A);
    chk(r_data == 32'h0000AABB, "R6 read extract 16b", r_data, 32'h0000AABB);
    chk(vcnt - v0 == 1, "R9 normal one cycle", vcnt - v0, 1);
  endtask

  task automatic t_type0_dword;
    tmode = 1; rbase = 32'h12345678 - hs;
    access(0, 8'd0, 5'd11, 3'd0, 8'h10, 3'd4, 0, 0, 0);
    chk(c_addr == 32'h00200010, "R1 type0 dev11", c_addr, 32'h00200010);
    chk(c_cmd == 8'h0A, "R3 be size4", {24'd0, c_cmd}, 32'h0A);
    chk(r_data == 32'h12345678, "R6 read full word", r_data, 32'h12345678);
  endtask

  task automatic t_type1_write;
    tmode = 1;
    access(1, 8'd5, 5'd3, 3'd1, 8'h41, 3'd1, 32'h5A, 0, 0);
    chk(c_addr == 32'h00051941, "R2 type1 addr", c_addr, 32'h00051941);
    chk(c_cmd == 8'hDB, "R3 be size1 lane1 write", {24'd0, c_cmd}, 32'hDB);
    chk(c_wdata == 32'h00005A00, "R5 write shift", c_wdata, 32'h00005A00);
    chk(!r_nf, "R7 no abort on ack", {31'd0, r_nf}, 0);
  endtask

  task automatic t_byte_read_lane3;
    tmode = 1; rbase = 32'hC3000000 - hs;
    access(0, 8'd2, 5'd0, 3'd0, 8'h07, 3'd1, 0, 0, 0);
    chk(c_addr == 32'h00020005, "R2 type1 bus2", c_addr, 32'h00020005);
    chk(c_cmd == 8'h7A, "R3 be size1 lane3", {24'd0, c_cmd}, 32'h7A);
    chk(r_data == 32'h000000C3, "R6 read byte lane3", r_data, 32'hC3);
  endtask

  task automatic t_bad_size;
    tmode = 1;
    access(0, 8'd0, 5'd1, 3'd0, 8'h00, 3'd3, 0, 0, 0);
    chk(r_bad, "R4 bad_reg", {31'd0, r_bad}, 1);
    chk(r_data == 32'hFFFFFFFF, "R4 bad read ones", r_data, 32'hFFFFFFFF);
    chk(vcnt - v0 == 0, "R4 no target cycle", vcnt - v0, 0);
  endtask

  task automatic t_abort;
    tmode = 2;
    access(0, 8'd0, 5'd4, 3'd0, 8'h00, 3'd4, 0, 0, 0);
    chk(r_nf, "R7 not_found", {31'd0, r_nf}, 1);
    chk(r_data == 32'hFFFFFFFF, "R7 failed read ones", r_data, 32'hFFFFFFFF);
    chk(abort_sts, "R7 sticky set", {31'd0, abort_sts}, 1);
    repeat (3) @(negedge clk);
    chk(abort_sts, "R8 sticky holds", {31'd0, abort_sts}, 1);
    abort_clr = 1; @(negedge clk); abort_clr = 0;
    chk(!abort_sts, "R8 cleared by pulse", {31'd0, abort_sts}, 0);
  endtask

  task automatic t_timeout_busy;
    tmode = 0;
    access(0, 8'd1, 5'd2, 3'd0, 8'h08, 3'd4, 0, 0, 1);
    chk(vcnt - v0 == 16, "R11 valid cycles", vcnt - v0, 16);
    chk(r_nf && abort_sts, "R11 timeout aborts", {30'd0, r_nf, abort_sts}, 3);
    chk(!busy && vcnt - v0 == 16, "R10 busy request dropped", {31'd0, busy}, 0);
    abort_clr = 1; @(negedge clk); abort_clr = 0;
  endtask

  task automatic t_errata;
    tmode = 1; rbase = 32'h10000000;
    access(0, 8'd0, 5'd5, 3'd0, 8'h00, 3'd4, 0, 1, 0);
    chk(hs - h0 == 8, "R9 eight handshakes", hs - h0, 8);
    chk(r_data == 32'h10000000 + h0 + 7, "R9 last word kept", r_data, 32'h10000000 + h0 + 7);
    access(1, 8'd0, 5'd5, 3'd0, 8'h00, 3'd4, 32'h1, 1, 0);
    chk(vcnt - v0 == 1, "R9 write single cycle", vcnt - v0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_type0_read();
    t_type0_dword();
    t_type1_write();
    t_byte_read_lane3();
    t_bad_size();
    t_abort();
    t_timeout_busy();
    t_errata();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule